// File: doc/BRIEF.md
# End-Around-Carry Ring Adder

This block adds two 16-bit words in ones-complement arithmetic within a single combinational path. Any carry out of the top bit re-enters at bit 0 inside the block. The block therefore has no carry input and no carry output. It is the arithmetic core for running packet checksums: an accumulator register placed around it keeps a partial sum, and the final fold and inversion happen elsewhere.

A parameter selects one of two internal structures. The first is a toroidal lookahead network. Each bit's incoming carry is an OR over generate terms taken around the whole ring, so every bit position has the same logic depth and fan-in. The second is a reference structure of two chained twos-complement adds. The first add produces a 17-bit result, and the second add feeds that result's top bit back into the low 16 bits. Both structures give identical results, so the reference serves as a cross-check or as a fallback for area.

Top module: `eac_ring_adder`

## Requirements
- R1: `sum_o` equals the ones-complement sum of `opnd_x` and `opnd_y`. When x+y is 0 the result is 0x0000. Otherwise the result is (x+y) mod 0xFFFF, and a remainder of 0 is returned as 0xFFFF.
- R2: A carry out of bit 15 is added back into bit 0, so 0x8000 + 0x8000 gives 0x0001.
- R3: The result 0xFFFF (negative zero) is produced as is and is never normalised, so 0xFFFF + 0x0000 gives 0xFFFF.
- R4: An operand of 0x0000 on either side returns the other operand unchanged.
- R5: The result is 0x0000 only when both operands are 0x0000.
- R6: An operand added to its bitwise complement gives 0xFFFF.
- R7: Swapping the two operands does not change the result.
- R8: `KIND` = KIND_RING (the toroidal lookahead) and `KIND` = KIND_REFERENCE (two chained adds) give identical results for every operand pair.
- R9: A carry generated at one bit can travel the whole ring back to that same bit, so 0xFFFF + 0x0001 gives 0x0001.
- R10: In the ring structure, a bit has no incoming carry when no bit generates one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | 16 | First operand |
| opnd_y | input | 16 | Second operand |
| sum_o | output | 16 | Ones-complement sum with end-around carry |

## Verification
The embedded assertions are immediate checks on a purely combinational path. They assume the operands are two-state and hold steady long enough for the sum to settle before anyone looks at it. The stimulus respects this: it changes both operands together, once per clock, just after the rising edge, and reads the outputs of both structures only at the falling edge. Expected values come from a modular formula rather than from adder logic. The stimulus covers random pairs, a cross product of the corner words 0x0000, 0xFFFF and 0x8000 together with their neighbours, and swapped and complemented pairs.

// File: rtl/ring_add_pkg.sv
package ring_add_pkg;
    typedef enum logic {
        KIND_REFERENCE = 1'b0,
        KIND_RING      = 1'b1
    } adder_kind_e;
endpackage

// File: rtl/eac_lookahead_ring.sv
module eac_lookahead_ring #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    output logic [WIDTH-1:0] sum_o
);
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    typedef struct packed {
        logic [WIDTH-1:0] gen;
        logic [WIDTH-1:0] prop;
        logic [WIDTH-1:0] carry;
    } ring_state_t;

    ring_state_t ring_d;

    // Each bit's carry walks backwards around the whole ring. The span
    // includes the bit itself, so a carry can wrap all the way round.
    always_comb begin
        ring_d.gen   = opnd_x & opnd_y;
        ring_d.prop  = opnd_x | opnd_y;
        ring_d.carry = '0;
        for (int i = 0; i < WIDTH; i++) begin
            logic run;
            logic acc;
            run = 1'b1;
            acc = 1'b0;
            for (int d = 1; d <= WIDTH; d++) begin
                logic [IDXW-1:0] j;
                j   = IDXW'((i - d + WIDTH) % WIDTH);
                acc = acc | (ring_d.gen[j] & run);
                run = run & ring_d.prop[j];
            end
            ring_d.carry[i] = acc;
        end
    end

    assign sum_o = opnd_x ^ opnd_y ^ ring_d.carry;

    // R10: without any generate term, no carry can appear anywhere
    always_comb begin
        if (ring_d.gen == '0) begin
            a_r10_no_gen_no_carry: assert (ring_d.carry == '0)
                else $error("ring carry without generate");
        end
    end
endmodule

// File: rtl/eac_twin_pass.sv
module eac_twin_pass #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    output logic [WIDTH-1:0] sum_o
);
    localparam int WIDE = WIDTH + 1;

    typedef struct packed {
        logic [WIDE-1:0] first;
        logic [WIDE-1:0] second;
    } pass_state_t;

    pass_state_t pass_d;

    always_comb begin
        pass_d.first  = {1'b0, opnd_x} + {1'b0, opnd_y};
        pass_d.second = {1'b0, pass_d.first[WIDTH-1:0]}
                      + {{WIDTH{1'b0}}, pass_d.first[WIDTH]};
    end

    assign sum_o = pass_d.second[WIDTH-1:0];

    // R2: folding the carry back in never overflows a second time
    always_comb begin
        a_r2_fold_no_overflow: assert (pass_d.second[WIDTH] == 1'b0)
            else $error("second pass overflowed");
    end
endmodule

// File: rtl/eac_ring_adder.sv
module eac_ring_adder #(
    parameter int                        WIDTH = 16,
    parameter ring_add_pkg::adder_kind_e KIND  = ring_add_pkg::KIND_RING
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    output logic [WIDTH-1:0] sum_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] core_sum_d;

    generate
        if (KIND == ring_add_pkg::KIND_RING) begin : g_ring
            eac_lookahead_ring #(.WIDTH(WIDTH)) core_i (
                .opnd_x(opnd_x),
                .opnd_y(opnd_y),
                .sum_o (core_sum_d)
            );
        end else begin : g_ref
            eac_twin_pass #(.WIDTH(WIDTH)) core_i (
                .opnd_x(opnd_x),
                .opnd_y(opnd_y),
                .sum_o (core_sum_d)
            );
        end
    endgenerate

    assign sum_o = core_sum_d;

    always_comb begin
        if (opnd_x == '0) begin
            a_r4_zero_identity: assert (sum_o == opnd_y)
                else $error("zero operand altered the other");
        end
        if (sum_o == '0) begin
            a_r5_zero_only_from_zeros: assert (opnd_x == '0 && opnd_y == '0)
                else $error("positive zero from nonzero operands");
        end
        if (opnd_x == ~opnd_y) begin
            a_r6_complement_pair: assert (sum_o == ALL_ONES)
                else $error("x plus not x is not all ones");
        end
    end
endmodule

// File: tb/eac_ring_adder_tb_top.sv
module eac_ring_adder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] opnd_x = '0;
    logic [15:0] opnd_y = '0;
    logic [15:0] sum_ring;
    logic [15:0] sum_ref;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [47:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    eac_ring_adder #(.WIDTH(16), .KIND(ring_add_pkg::KIND_RING)) dut_i (
        .opnd_x(opnd_x), .opnd_y(opnd_y), .sum_o(sum_ring)
    );
    eac_ring_adder #(.WIDTH(16), .KIND(ring_add_pkg::KIND_REFERENCE)) ref_i (
        .opnd_x(opnd_x), .opnd_y(opnd_y), .sum_o(sum_ref)
    );

    function automatic logic [15:0] ones_sum(input logic [15:0] x, input logic [15:0] y);
        int unsigned t;
        t = int'(x) + int'(y);
        if (t == 0) return 16'h0000;
        t = t % 65535;
        if (t == 0) return 16'hFFFF;
        return 16'(t);
    endfunction

    task automatic drive(input logic [15:0] x, input logic [15:0] y, input string tag);
        @(posedge clk);
        #1;
        opnd_x = x;
        opnd_y = y;
        exp_q.push_back({x, y, ones_sum(x, y)});
        tag_q.push_back(tag);
    endtask

    task automatic drive_fixed(input logic [15:0] x, input logic [15:0] y,
                               input logic [15:0] e, input string tag);
        @(posedge clk);
        #1;
        opnd_x = x;
        opnd_y = y;
        exp_q.push_back({x, y, e});
        tag_q.push_back(tag);
    endtask

    // monitor: scoreboard compare at falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [47:0] it;
            string tg;
            it = exp_q.pop_front();
            tg = tag_q.pop_front();
            tests++;
            if (sum_ring !== it[15:0]) begin
                fails++;
                $display("FAIL %s ring x=%h y=%h actual=%h expected=%h",
                         tg, it[47:32], it[31:16], sum_ring, it[15:0]);
            end
            tests++;
            if (sum_ref !== sum_ring) begin
                fails++;
                $display("FAIL R8 x=%h y=%h actual(ref)=%h expected(ring)=%h",
                         it[47:32], it[31:16], sum_ref, sum_ring);
            end
        end
    end

    initial begin
        int cycles;
        cycles = 0;
        while (!finished && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] corners [6];
        corners = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'h7FFF, 16'hFFFE};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: operands idle at zero give positive zero (R5)
        drive_fixed(16'h0000, 16'h0000, 16'h0000, "R5 idle");
        drive_fixed(16'h8000, 16'h8000, 16'h0001, "R2 wrap");
        drive_fixed(16'hFFFF, 16'h0000, 16'hFFFF, "R3 neg zero");
        drive_fixed(16'h0000, 16'hFFFF, 16'hFFFF, "R3 neg zero swapped");
        drive_fixed(16'hFFFF, 16'h0001, 16'h0001, "R9 full ring");
        drive_fixed(16'hFFFF, 16'hFFFF, 16'hFFFF, "R9 all generate");
        drive_fixed(16'h0000, 16'h1234, 16'h1234, "R4 zero left");
        drive_fixed(16'hABCD, 16'h0000, 16'hABCD, "R4 zero right");
        drive_fixed(16'h0F0F, 16'hF0F0, 16'hFFFF, "R6 complement");
        drive_fixed(16'h0001, 16'h0002, 16'h0003, "R10 no generate");
        for (int i = 0; i < 6; i++)
            for (int k = 0; k < 6; k++)
                drive(corners[i], corners[k], "R1 corner");
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] x;
            logic [15:0] y;
            x = 16'($urandom);
            y = 16'($urandom);
            drive(x, y, "R1 random");
            drive(y, x, "R7 swapped");
            drive(x, ~x, "R6 random complement");
        end
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule